// File: doc/BRIEF.md
# Channel Completion-Interrupt Enable Bank

This block keeps one interrupt-enable bit for each of 64 DMA channels and turns the channels' completion events into a single interrupt line. The enable bits are split into two 32-bit words. Channels 0 to 31 sit in the low word and channels 32 to 63 in the high word. Software reads them as read-only words. It changes them only through separate write-one-to-set and write-one-to-clear alias words. Because of this, two agents can each change their own channels without a read-modify-write race.

A simple single-cycle register port carries the accesses. It has a word address, write data, a write strobe and a read strobe. Read data arrives on the cycle after the read strobe. The pending-completion vector comes from the transfer engine. The block ANDs it with the enables, ORs the result together and registers it to form the interrupt output. The current pending vector can also be read back through two more words.

Top module: `irq_enable_bank`

## Requirements
- R1: The enable state covers 64 channels in two read-only words: word offset 0 holds channels 0-31 and offset 1 holds channels 32-63, with bit n of a word standing for channel 32*offset+n.
- R2: A write to word offset 0 or 1, and any cycle without a write, leaves every enable bit unchanged.
- R3: A write to offset 2 (low word) or 3 (high word) sets each enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A write to offset 4 (low word) or 5 (high word) clears each enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: After reset all enable bits are 0, the interrupt output is 0 and the read data is 0.
- R6: The interrupt output is 1 exactly when, in the previous cycle, some channel had both its pending input and its enable bit at 1.
- R7: Reads of the set and clear aliases (offsets 2 to 5) return zero.
- R8: Reads of offset 6 and offset 7 return the pending input for channels 0-31 and 32-63 respectively.
- R9: Read data is valid on the cycle after the read strobe and holds its value until the next read. A write takes effect at its own clock edge, so a read in the following cycle returns the updated enable value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| pend_i | input | 64 | Per-channel completion pending flags |
| irq_o | output | 1 | Combined, registered completion interrupt |

## Verification
The assertions take a few things for granted. Every address on the port decodes to one of the eight offsets. A write and a read may share a cycle, and in that case the read returns the value from before the write. The pending vector may change freely from one cycle to the next. The stimulus draws the offset from the full 3-bit range and the strobes independently, and draws fresh random pending vectors on every cycle. Directed sequences cover the all-ones and all-zero masks, the edge channels 0, 31, 32 and 63, and writes to the read-only words.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Register group selected by the upper address bits; the order fixes the map.
  typedef enum logic [1:0] {
    GRP_ENABLE = 2'd0,
    GRP_SET    = 2'd1,
    GRP_CLEAR  = 2'd2,
    GRP_PEND   = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 1,
  parameter int ADDR_W    = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  output logic [NUM_WORDS-1:0] set_stb,
  output logic [NUM_WORDS-1:0] clr_stb,
  output reg_grp_e             grp,
  output logic [WIDX_W-1:0]    word
);
  assign grp  = reg_grp_e'(addr[ADDR_W-1:WIDX_W]);
  assign word = addr[WIDX_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stb
    assign set_stb[w] = we && (grp == GRP_SET)   && (word == WIDX_W'(w));
    assign clr_stb[w] = we && (grp == GRP_CLEAR) && (word == WIDX_W'(w));
  end
endmodule

// File: rtl/irq_enable_word.sv
module irq_enable_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  logic [DATA_W-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_d = en_q;
    if (set_stb) en_d = en_q | wdata;
    if (clr_stb) en_d = en_q & ~wdata;
  end

  assign en_ce = set_stb | clr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
  import irq_bank_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 1
) (
  input  reg_grp_e            grp,
  input  logic [WIDX_W-1:0]   word,
  input  logic [NUM_CH-1:0]   en_vec,
  input  logic [NUM_CH-1:0]   pend,
  output logic [DATA_W-1:0]   rd_next
);
  logic [DATA_W-1:0] en_words   [NUM_WORDS];
  logic [DATA_W-1:0] pend_words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_split
    assign en_words[w]   = en_vec[w*DATA_W +: DATA_W];
    assign pend_words[w] = pend[w*DATA_W +: DATA_W];
  end

  always_comb begin
    unique case (grp)
      GRP_ENABLE: rd_next = en_words[word];
      GRP_PEND:   rd_next = pend_words[word];
      default:    rd_next = '0;
    endcase
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] en_vec,
  output logic              irq_q
);
  logic irq_d;

  assign irq_d = |(pend & en_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  localparam int NUM_WORDS = NUM_CH / DATA_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] pend_i,
  output logic              irq_o
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_WORDS-1:0] set_stb, clr_stb;
  reg_grp_e             grp;
  logic [WIDX_W-1:0]    word;
  logic [NUM_CH-1:0]    en_vec;
  logic [DATA_W-1:0]    rd_next;
  logic [DATA_W-1:0]    rdata_q;

  irq_bank_decode #(.NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .set_stb(set_stb), .clr_stb(clr_stb),
    .grp(grp), .word(word)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    irq_enable_word #(.DATA_W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_int_n), .set_stb(set_stb[w]), .clr_stb(clr_stb[w]),
      .wdata(bus_wdata), .en_q(en_vec[w*DATA_W +: DATA_W])
    );
  end

  irq_bank_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
                   .WIDX_W(WIDX_W)) u_rd (
    .grp(grp), .word(word), .en_vec(en_vec), .pend(pend_i), .rd_next(rd_next)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_next;
  end
  assign bus_rdata = rdata_q;

  irq_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .pend(pend_i), .en_vec(en_vec), .irq_q(irq_o)
  );
endmodule

// File: rtl/irq_enable_bank_chk.sv
module irq_enable_bank_chk #(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] pend_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] en_vec
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [1:0]        grp;
  logic [WIDX_W-1:0] word;
  logic [NUM_CH-1:0] wmask;
  logic              hit;

  assign grp   = bus_addr[ADDR_W-1:WIDX_W];
  assign word  = bus_addr[WIDX_W-1:0];
  assign wmask = NUM_CH'(bus_wdata) << (DATA_W * word);
  assign hit   = |(pend_i & en_vec);

  AST_EN_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && grp == 2'd0) |=> en_vec == $past(en_vec)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(en_vec)); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && grp == 2'd1) |=> (en_vec & $past(en_vec)) == $past(en_vec)); // R3
  AST_SET_HITS: assert property (@(posedge clk) disable iff (!rst_n || !$past(rst_n))
    (bus_we && grp == 2'd1) |=> (en_vec & $past(wmask)) == $past(wmask)); // R3
  AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && grp == 2'd2) |=> (en_vec & ~$past(en_vec)) == '0); // R4
  AST_CLR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && grp == 2'd2) |=> (en_vec & $past(wmask)) == '0); // R4
  AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (grp == 2'd1 || grp == 2'd2)) |=> bus_rdata == '0); // R7
  AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(hit)); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit) |-> irq_o); // R6
endmodule

bind irq_enable_bank irq_enable_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W))
  u_chk (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
         .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pend_i(pend_i),
         .irq_o(irq_o), .en_vec(en_vec));

// File: tb/irq_enable_bank_test.sv
module irq_enable_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic [63:0] pend_i;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [63:0] model_en;
  logic [31:0] exp_rd;

  always #5 clk = ~clk;

  irq_enable_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pend_i(pend_i),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] read_value(input logic [2:0] a, input logic [63:0] en,
                                             input logic [63:0] p);
    case (a)
      3'd0: return en[31:0];
      3'd1: return en[63:32];
      3'd6: return p[31:0];
      3'd7: return p[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [63:0] next_en(input logic [2:0] a, input logic [31:0] d,
                                          input logic [63:0] en);
    case (a)
      3'd2: return en | {32'h0, d};
      3'd3: return en | {d, 32'h0};
      3'd4: return en & ~{32'h0, d};
      3'd5: return en & ~{d, 32'h0};
      default: return en;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    if (a < 3'd2) return "R1";
    if (a < 3'd6) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, then check at the next falling edge.
  task automatic cycle(input logic we, input logic re, input logic [2:0] a,
                       input logic [31:0] d, input logic [63:0] p);
    logic exp_irq;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; pend_i = p;
    exp_irq = |(p & model_en);
    if (re) exp_rd = read_value(a, model_en, p);
    if (we) model_en = next_en(a, d, model_en);
    @(negedge clk);
    check("R6 irq", {63'h0, irq_o}, {63'h0, exp_irq});
    if (re) check({read_tag(a), " R9 read"}, {32'h0, bus_rdata}, {32'h0, exp_rd});
    else    check("R9 hold", {32'h0, bus_rdata}, {32'h0, exp_rd});
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] p);
    cycle(1'b0, 1'b1, a, 32'h0, p);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [63:0] p);
    cycle(1'b1, 1'b0, a, d, p);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0; pend_i = '1;
    model_en = '0; exp_rd = '0;
    repeat (3) @(negedge clk);
    check("R5 reset irq", {63'h0, irq_o}, 64'h0);
    check("R5 reset rdata", {32'h0, bus_rdata}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: enables are zero after reset, so all-ones pending gives no interrupt
    rd(3'd0, '1); rd(3'd1, '1);
    // R2: direct writes to the enable words are ignored
    wr(3'd0, 32'hffff_ffff, '1); wr(3'd1, 32'hffff_ffff, '1);
    rd(3'd0, '1); rd(3'd1, '1);
    // R3: set channel 0 and channel 63; R9 read right after the write
    wr(3'd2, 32'h0000_0001, 64'h0); rd(3'd0, 64'h1);
    wr(3'd3, 32'h8000_0000, 64'h0); rd(3'd1, 64'h8000_0000_0000_0000);
    // R3: bits written as 0 leave others alone
    wr(3'd2, 32'h8000_0000, 64'h0); rd(3'd0, 64'h0);
    // R6: channel 31 pending but channel 32 not enabled
    cycle(1'b0, 1'b0, 3'd0, 32'h0, 64'h0000_0001_0000_0000);
    cycle(1'b0, 1'b0, 3'd0, 32'h0, 64'h0000_0000_8000_0000);
    // R4: clear channel 0 only
    wr(3'd4, 32'h0000_0001, 64'h1); rd(3'd0, 64'h1);
    wr(3'd5, 32'hffff_ffff, '1); rd(3'd1, '1);
    // R7 / R8: alias and pending readback
    rd(3'd2, '1); rd(3'd5, '1); rd(3'd6, 64'h1234_5678_9abc_def0); rd(3'd7, 64'h1234_5678_9abc_def0);
    // R3 / R4: set all, clear all
    wr(3'd2, '1, '0); wr(3'd3, '1, '0); rd(3'd1, '1);
    wr(3'd4, '1, '1); wr(3'd5, '1, '1); rd(3'd0, '1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom} & {$urandom, $urandom};
      cycle(($urandom % 3) == 0, ($urandom % 2) == 0, 3'($urandom), $urandom, p);
    end
    for (int a = 0; a < 8; a++) rd(3'(a), {$urandom, $urandom});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule